// File: doc/BRIEF.md
# Multiplexed MDIO Management Master

This block is a management-bus master controlled through registers. It runs one MDIO frame at a time on one of several MDIO segments. Half of the segments are internal and half are external. Software first loads a parameter word, which holds the segment choice, the PHY address, the write data and a Clause 45 flag. It then loads an address word. Writing a command to the control register starts the transaction. Software polls a done bit until the frame completes, reads the captured data if the transaction was a read, and clears the command to re-arm the engine.

The MDC clock is derived from the core clock. The divider setting comes from one of two rate registers: one applies to internal segments and one to external segments. Only the addressed segment toggles. Every other segment keeps MDC and MDIO high with the output enable low. A single ownership bit is exported so that surrounding logic can lock out any outside master.

Top module: `mdio_mux_master`

## Requirements
- R1: After reset the following hold: status reads 0, both rate registers read 0x0000_0002, every MDC and MDIO line is high, every output enable is low, and the ownership output is low.
- R2: Register readback at byte offsets:
  - 0x000 returns the external rate word and 0x004 the internal rate word, each in full.
  - 0x23C returns the parameter word masked with 0x23FF_FFFF.
  - 0x244 returns the address word in full.
  - 0x240 returns the read data in bits 15:0, with zeros above.
  - 0x24C returns done in bit 0.
  - Any offset at or beyond 0x250 reads 0.
- R3: Writing 1 to control (0x248) sends a Clause 22 write frame, when parameter bit 21 is 0. Bits are launched MSB first in this order: 32 ones, start 01, opcode 01, PHY address (parameter bits 20:16), register address (address bits 4:0), turnaround 10, data (parameter bits 15:0).
- R4: Writing 2 to control sends a Clause 22 read frame with opcode 10. The master releases the line (output enable low) for the 2 turnaround bits and the 16 data bits. It samples the 16 data bits MSB first on rising MDC edges into read data.
- R5: With parameter bit 21 set, a Clause 45 transaction sends two back-to-back 64-bit frames, both with start 00 and the device address taken from address bits 20:16:
  - First, an address frame with opcode 00 that carries address bits 15:0.
  - Then a data frame with opcode 01 for a write or 11 for a read.
- R6: One MDC period lasts div*(dvd+1) core cycles, with a minimum of 2. Here div is bits 15:0 and dvd is bits 31:16 of the rate register for the selected side: 0x004 when bit 25 is set, 0x000 otherwise. The register is captured at start. Done becomes visible exactly 64 periods per frame after the accepting clock edge.
- R7: Done stays at 1 until control is written with 0. After that write it reads 0.
- R8: A write of 1 or 2 to control while a frame is in progress is ignored. The frame, its timing and its result are unchanged.
- R9: Writing 0 to control in the middle of a frame stops it at once. On the next cycle all lines are idle and done is 0.
- R10: Parameter bit 25 set selects internal segment N, where N is bus id bits 23:22. Bit 25 clear selects external segment SEG_PER_SIDE+N. Only the selected segment toggles MDC or enables its driver.
- R11: Bit 28 of scan control (0x008) drives `ext_own_o` and reads back. All other bits of that register read as 0.
- R12: A control value other than 0, 1 or 2 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | core clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| reg_we_i | input | 1 | register write strobe |
| reg_addr_i | input | AW | register byte address |
| reg_wdata_i | input | 32 | register write data |
| reg_rdata_o | output | 32 | register read data (combinational) |
| mdc_o | output | 2*SEG_PER_SIDE | per-segment MDC |
| mdio_o | output | 2*SEG_PER_SIDE | per-segment MDIO drive value |
| mdio_oe_o | output | 2*SEG_PER_SIDE | per-segment MDIO output enable |
| mdio_i | input | 2*SEG_PER_SIDE | per-segment MDIO input |
| ext_own_o | output | 1 | external master lock-out |

## Verification
The bench captures every bit the master drives on rising MDC edges. It compares that stream against frames built from the field definitions, so a wrong opcode, a wrong start code, or a turnaround that is driven instead of released shows up as a bit mismatch. It measures the cycles from command to done on both rate registers, using an odd period and Clause 45 double frames. An off-by-one period count, or the wrong side's divider, shifts that count. It also aborts mid-frame, re-issues commands while busy, and writes an illegal command value. A design that restarted, extended or stalled in any of these cases would show a wrong done, wrong lines or altered data. It records which segments' MDC went low, so a stray toggle on a neighbour segment is caught.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam logic [11:0] A_RATE_EXT = 12'h000;
  localparam logic [11:0] A_RATE_INT = 12'h004;
  localparam logic [11:0] A_SCAN     = 12'h008;
  localparam logic [11:0] A_PARAM    = 12'h23C;
  localparam logic [11:0] A_RDATA    = 12'h240;
  localparam logic [11:0] A_ADDR     = 12'h244;
  localparam logic [11:0] A_CTRL     = 12'h248;
  localparam logic [11:0] A_STAT     = 12'h24C;
  localparam logic [31:0] PARAM_MASK = 32'h23FF_FFFF;
  localparam int unsigned FRAME_BITS = 64;
  localparam int unsigned TA_FIRST   = 46;
  localparam int unsigned DATA_FIRST = 48;

  // 64-bit frame, bit 63 launched first
  function automatic logic [63:0] frame_word(input logic c45, input logic rd, input logic aph,
                                             input logic [4:0] phy, input logic [4:0] regf,
                                             input logic [15:0] val);
    logic [1:0] st, op;
    st = c45 ? 2'b00 : 2'b01;
    if (!c45)     op = rd ? 2'b10 : 2'b01;
    else if (aph) op = 2'b00;
    else          op = rd ? 2'b11 : 2'b01;
    return {32'hFFFF_FFFF, st, op, phy, regf, 2'b10, val};
  endfunction
endpackage

// File: rtl/mdm_regs.sv
module mdm_regs import mdm_pkg::*; #(
  parameter int unsigned AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  input  logic          done_i,
  input  logic [15:0]   rdat_i,
  output logic [31:0]   rdata_o,
  output logic [31:0]   rate_ext_o,
  output logic [31:0]   rate_int_o,
  output logic [31:0]   param_o,
  output logic [31:0]   addr_o,
  output logic          own_o,
  output logic          cmd_wr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_ext_o <= 32'd2;
      rate_int_o <= 32'd2;
      param_o    <= '0;
      addr_o     <= '0;
      own_o      <= 1'b0;
    end else if (we_i) begin
      if (addr_i == AW'(A_RATE_EXT)) rate_ext_o <= wdata_i;
      if (addr_i == AW'(A_RATE_INT)) rate_int_o <= wdata_i;
      if (addr_i == AW'(A_SCAN))     own_o      <= wdata_i[28];
      if (addr_i == AW'(A_PARAM))    param_o    <= wdata_i & PARAM_MASK;
      if (addr_i == AW'(A_ADDR))     addr_o     <= wdata_i;
    end
  end

  assign cmd_wr_o = we_i && (addr_i == AW'(A_CTRL));

  always_comb begin
    rdata_o = '0;
    if      (addr_i == AW'(A_RATE_EXT)) rdata_o = rate_ext_o;
    else if (addr_i == AW'(A_RATE_INT)) rdata_o = rate_int_o;
    else if (addr_i == AW'(A_SCAN))     rdata_o = {3'b0, own_o, 28'b0};
    else if (addr_i == AW'(A_PARAM))    rdata_o = param_o;
    else if (addr_i == AW'(A_RDATA))    rdata_o = {16'b0, rdat_i};
    else if (addr_i == AW'(A_ADDR))     rdata_o = addr_o;
    else if (addr_i == AW'(A_STAT))     rdata_o = {31'b0, done_i};
  end
endmodule

// File: rtl/mdm_rate.sv
module mdm_rate (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic        run_i,
  input  logic [15:0] div_i,
  input  logic [15:0] dvd_i,
  output logic        mdc_o,
  output logic        bit_end_o,
  output logic        sample_o
);
  logic [31:0] per_d, per_q, half_q, cnt_q;

  always_comb begin
    per_d = {16'b0, div_i} * ({16'b0, dvd_i} + 32'd1);
    if (per_d < 32'd2) per_d = 32'd2;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= 32'd2;
      half_q <= 32'd1;
      cnt_q  <= '0;
    end else if (load_i) begin
      per_q  <= per_d;
      half_q <= per_d >> 1;
      cnt_q  <= '0;
    end else if (run_i) begin
      cnt_q <= bit_end_o ? '0 : cnt_q + 32'd1;
    end else begin
      cnt_q <= '0;
    end
  end

  // low half first: MDC falls at bit start, rises at mid-bit
  assign mdc_o     = cnt_q >= half_q;
  assign bit_end_o = run_i && (cnt_q == per_q - 32'd1);
  assign sample_o  = run_i && (cnt_q == half_q);
endmodule

// File: rtl/mdm_engine.sv
module mdm_engine import mdm_pkg::*; #(
  parameter int unsigned SW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_wr_i,
  input  logic [31:0]   cmd_i,
  input  logic          c45_i,
  input  logic [4:0]    phy_i,
  input  logic [4:0]    regf_i,
  input  logic [15:0]   wdata_i,
  input  logic [15:0]   addr16_i,
  input  logic [SW-1:0] seg_i,
  input  logic          bit_end_i,
  input  logic          sample_i,
  input  logic          mdio_in_i,
  output logic          start_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [SW-1:0] seg_o,
  output logic          bit_o,
  output logic          oe_o,
  output logic [15:0]   rdata_o
);
  logic        c45_q, rd_q, aph_q;
  logic [5:0]  bidx_q;
  logic [4:0]  phy_q, regf_q;
  logic [15:0] wd_q, ad_q;
  logic [63:0] fw;
  logic        abort, in_data;

  assign start_o = cmd_wr_i && !busy_o && (cmd_i == 32'd1 || cmd_i == 32'd2);
  assign abort   = cmd_wr_i && (cmd_i == 32'd0);
  assign in_data = rd_q && !aph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0; done_o <= 1'b0; c45_q <= 1'b0; rd_q <= 1'b0; aph_q <= 1'b0;
      bidx_q <= '0; phy_q <= '0; regf_q <= '0; wd_q <= '0; ad_q <= '0;
      seg_o <= '0; rdata_o <= '0;
    end else if (abort) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else if (start_o) begin
      busy_o <= 1'b1; done_o <= 1'b0; bidx_q <= '0;
      c45_q <= c45_i; aph_q <= c45_i; rd_q <= cmd_i[1];
      phy_q <= phy_i; regf_q <= regf_i; wd_q <= wdata_i; ad_q <= addr16_i;
      seg_o <= seg_i;
    end else if (busy_o) begin
      if (sample_i && in_data && bidx_q >= 6'(DATA_FIRST))
        rdata_o <= {rdata_o[14:0], mdio_in_i};
      if (bit_end_i) begin
        if (bidx_q == 6'(FRAME_BITS - 1)) begin
          bidx_q <= '0;
          if (aph_q) aph_q <= 1'b0;
          else begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end
        end else begin
          bidx_q <= bidx_q + 6'd1;
        end
      end
    end
  end

  assign fw    = frame_word(c45_q, rd_q, aph_q, phy_q, regf_q, aph_q ? ad_q : wd_q);
  assign bit_o = fw[6'd63 - bidx_q];
  assign oe_o  = busy_o && !(in_data && bidx_q >= 6'(TA_FIRST));
endmodule

// File: rtl/mdio_mux_master.sv
module mdio_mux_master import mdm_pkg::*; #(
  parameter int unsigned SEG_PER_SIDE = 4,
  parameter int unsigned AW           = 12
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      reg_we_i,
  input  logic [AW-1:0]             reg_addr_i,
  input  logic [31:0]               reg_wdata_i,
  output logic [31:0]               reg_rdata_o,
  output logic [2*SEG_PER_SIDE-1:0] mdc_o,
  output logic [2*SEG_PER_SIDE-1:0] mdio_o,
  output logic [2*SEG_PER_SIDE-1:0] mdio_oe_o,
  input  logic [2*SEG_PER_SIDE-1:0] mdio_i,
  output logic                      ext_own_o
);
  localparam int unsigned NSEG = 2 * SEG_PER_SIDE;
  localparam int unsigned SW   = $clog2(NSEG);
  localparam int unsigned IDW  = $clog2(SEG_PER_SIDE);

  logic [31:0]   rate_ext, rate_int, par_q, adr_q;
  logic          cmd_wr, done, busy, mdc_lvl, bit_end, sample, start, line_bit, line_oe, in_bit;
  logic [15:0]   rdat, div_sel, dvd_sel;
  logic [SW-1:0] seg_new, seg_cur;
  logic          int_sel, c45;
  logic [IDW-1:0] bus_id;

  assign int_sel = par_q[25];
  assign c45     = par_q[21];
  assign bus_id  = par_q[22 +: IDW];
  assign seg_new = int_sel ? SW'(bus_id) : SW'(SEG_PER_SIDE) + SW'(bus_id);
  assign div_sel = int_sel ? rate_int[15:0]  : rate_ext[15:0];
  assign dvd_sel = int_sel ? rate_int[31:16] : rate_ext[31:16];
  assign in_bit  = mdio_i[seg_cur];

  mdm_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .done_i(done), .rdat_i(rdat), .rdata_o(reg_rdata_o), .rate_ext_o(rate_ext),
    .rate_int_o(rate_int), .param_o(par_q), .addr_o(adr_q), .own_o(ext_own_o),
    .cmd_wr_o(cmd_wr)
  );

  mdm_rate u_rate (
    .clk_i, .rst_ni, .load_i(start), .run_i(busy), .div_i(div_sel), .dvd_i(dvd_sel),
    .mdc_o(mdc_lvl), .bit_end_o(bit_end), .sample_o(sample)
  );

  mdm_engine #(.SW(SW)) u_eng (
    .clk_i, .rst_ni, .cmd_wr_i(cmd_wr), .cmd_i(reg_wdata_i), .c45_i(c45),
    .phy_i(par_q[20:16]), .regf_i(c45 ? adr_q[20:16] : adr_q[4:0]),
    .wdata_i(par_q[15:0]), .addr16_i(adr_q[15:0]), .seg_i(seg_new),
    .bit_end_i(bit_end), .sample_i(sample), .mdio_in_i(in_bit),
    .start_o(start), .busy_o(busy), .done_o(done), .seg_o(seg_cur),
    .bit_o(line_bit), .oe_o(line_oe), .rdata_o(rdat)
  );

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic act;
    assign act          = busy && (seg_cur == SW'(s));
    assign mdc_o[s]     = act ? mdc_lvl : 1'b1;
    assign mdio_oe_o[s] = act && line_oe;
    assign mdio_o[s]    = (act && line_oe) ? line_bit : 1'b1;
  end
endmodule

// File: rtl/mdio_mux_master_chk.sv
module mdio_mux_master_chk import mdm_pkg::*; #(
  parameter int unsigned NSEG = 8,
  parameter int unsigned AW   = 12
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            reg_we_i,
  input logic [AW-1:0]   reg_addr_i,
  input logic [31:0]     reg_wdata_i,
  input logic [NSEG-1:0] mdc_o,
  input logic [NSEG-1:0] mdio_oe_o,
  input logic            ext_own_o,
  input logic            done_i
);
  logic ctrl_wr;
  assign ctrl_wr = reg_we_i && (reg_addr_i == AW'(A_CTRL));

  p_one_mdc_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~mdc_o));
  p_one_oe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mdio_oe_o));
  p_done_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !ctrl_wr) |=> done_i);
  p_abort_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && reg_wdata_i == 32'd0) |=> (!done_i && (&mdc_o) && (mdio_oe_o == '0)));
  p_own_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == AW'(A_SCAN)) |=> (ext_own_o == $past(reg_wdata_i[28])));
endmodule

bind mdio_mux_master mdio_mux_master_chk #(.NSEG(NSEG), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .mdc_o(mdc_o), .mdio_oe_o(mdio_oe_o),
  .ext_own_o(ext_own_o), .done_i(done)
);

// File: tb/sim_mdio_mux_master.sv
module sim_mdio_mux_master;
  localparam int CLK_PERIOD = 10;
  localparam int SPS  = 4;
  localparam int NSEG = 2 * SPS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NSEG-1:0] mdc, mdio_d, mdio_oe, mdio_in;
  logic ext_own;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_mux_master #(.SEG_PER_SIDE(SPS), .AW(12)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mdc_o(mdc), .mdio_o(mdio_d),
    .mdio_oe_o(mdio_oe), .mdio_i(mdio_in), .ext_own_o(ext_own)
  );

  // PHY responder across all segments
  logic mdc_all, line;
  logic [127:0] cap = '0;
  logic [NSEG-1:0] seen_low = '0;
  logic [15:0] phy_val = '0;
  logic drv = 1'b1;
  int nfall = 0;
  assign mdc_all = &mdc;
  assign line    = &(mdio_d | ~mdio_oe);
  assign mdio_in = {NSEG{drv}};

  always @(posedge mdc_all) cap <= {cap[126:0], line};
  always @(negedge mdc_all) begin
    int b;
    nfall = nfall + 1;
    seen_low = seen_low | ~mdc;
    b = (nfall - 1) % 64;
    drv = (b >= 48) ? phy_val[15 - (b - 48)] : 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [63:0] ef(bit c45, bit r, bit aph, logic [4:0] phy, logic [4:0] rf, logic [15:0] v);
    logic [1:0] st, op;
    logic [17:0] tail;
    st = c45 ? 2'b00 : 2'b01;
    op = !c45 ? (r ? 2'b10 : 2'b01) : (aph ? 2'b00 : (r ? 2'b11 : 2'b01));
    tail = (r && !aph) ? 18'h3FFFF : {2'b10, v};
    return {32'hFFFF_FFFF, st, op, phy, rf, tail};
  endfunction

  // one full transaction with frame, timing, segment and data checks
  task automatic do_op(input bit isint, input int bus, input bit c45, input bit r,
                       input logic [4:0] phy, input logic [4:0] dev, input logic [15:0] ra,
                       input logic [15:0] wd, input logic [15:0] pv, input int per, input bit poke);
    logic [31:0] d;
    logic [127:0] exp;
    int n, nfr, seg;
    bit got;
    nfr = c45 ? 2 : 1;
    seg = isint ? bus : SPS + bus;
    wr(12'h23C, (32'(isint) << 25) | (32'(bus) << 22) | (32'(c45) << 21) | (32'(phy) << 16) | 32'(wd));
    wr(12'h244, c45 ? {11'b0, dev, ra} : 32'(ra));
    wr(12'h248, 32'd0);
    nfall = 0; seen_low = '0; phy_val = pv; cap = '0;
    wr(12'h248, r ? 32'd2 : 32'd1);
    n = 0; got = 0;
    while (n < 3000) begin
      @(posedge clk); #1;
      n++;
      reg_we = 1'b0;
      if (poke && n == 50) begin
        reg_we = 1'b1; reg_addr = 12'h248; reg_wdata = r ? 32'd1 : 32'd2;
      end else begin
        reg_addr = 12'h24C; #1;
        if (reg_rdata[0]) begin got = 1; break; end
      end
    end
    reg_we = 1'b0;
    check(got && n == nfr * 64 * per, poke ? "R8 latency" : "R6 latency", 128'(n), 128'(nfr * 64 * per));
    exp = c45 ? {ef(1, r, 1, phy, dev, ra), ef(1, r, 0, phy, dev, wd)}
              : {64'b0, ef(0, r, 0, phy, ra[4:0], wd)};
    if (c45) check(cap == exp, "R5 frames", cap, exp);
    else     check(cap[63:0] == exp[63:0], r ? "R4 frame" : "R3 frame", 128'(cap[63:0]), exp);
    check(seen_low == NSEG'(1) << seg, "R10 segment", 128'(seen_low), 128'(NSEG'(1) << seg));
    if (r) begin
      rd(12'h240, d);
      check(d == {16'b0, pv}, "R4 read data", 128'(d), 128'({16'b0, pv}));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int unsigned sd;
    sd = $urandom(32'd4711);
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    rd(12'h24C, d); check(d == 0, "R1 status", 128'(d), 0);
    rd(12'h000, d); check(d == 2, "R1 ext rate", 128'(d), 2);
    rd(12'h004, d); check(d == 2, "R1 int rate", 128'(d), 2);
    check(mdc == '1 && mdio_d == '1 && mdio_oe == '0 && !ext_own, "R1 lines",
          128'({mdc, mdio_d, mdio_oe}), 128'({{2*NSEG{1'b1}}, {NSEG{1'b0}}}));
    rst_n = 1'b1;
    // R2 readback
    wr(12'h23C, 32'hFFFF_FFFF); rd(12'h23C, d); check(d == 32'h23FF_FFFF, "R2 param", 128'(d), 128'(32'h23FF_FFFF));
    wr(12'h244, 32'hDEAD_BEEF); rd(12'h244, d); check(d == 32'hDEAD_BEEF, "R2 addr", 128'(d), 128'(32'hDEAD_BEEF));
    rd(12'h250, d); check(d == 0, "R2 unmapped", 128'(d), 0);
    // R11 ownership
    wr(12'h008, 32'hFFFF_FFFF); rd(12'h008, d);
    check(d == 32'h1000_0000 && ext_own, "R11 set", 128'(d), 128'(32'h1000_0000));
    wr(12'h008, 32'h0); check(!ext_own, "R11 clear", 128'(ext_own), 0);
    // rates: internal P=2*(2+1)=6, external P=5*(0+1)=5
    wr(12'h004, 32'h0002_0002); wr(12'h000, 32'h0000_0005);
    rd(12'h004, d); check(d == 32'h0002_0002, "R2 int rate", 128'(d), 128'(32'h0002_0002));
    // directed
    do_op(1, 2, 0, 0, 5'h11, 5'h0, 16'h001A, 16'hA5C3, 16'h0, 6, 0);
    do_op(0, 3, 0, 1, 5'h03, 5'h0, 16'h0002, 16'h0, 16'h9E71, 5, 0);
    do_op(1, 0, 1, 1, 5'h1F, 5'h07, 16'h8001, 16'h0, 16'h4C2B, 6, 0);
    do_op(0, 0, 1, 0, 5'h00, 5'h1E, 16'hFFFE, 16'h1234, 16'h0, 5, 0);
    do_op(1, 1, 0, 1, 5'h0A, 5'h0, 16'h0015, 16'h0, 16'hF00D, 6, 1);
    // R7 done holds, clears on 0
    repeat (20) @(posedge clk);
    #1; rd(12'h24C, d); check(d == 1, "R7 done held", 128'(d), 1);
    // R12 illegal command
    wr(12'h248, 32'd3); rd(12'h24C, d);
    check(d == 1 && mdc == '1, "R12 no effect", 128'({d[0], mdc}), 128'({1'b1, {NSEG{1'b1}}}));
    wr(12'h248, 32'd0); rd(12'h24C, d); check(d == 0, "R7 done cleared", 128'(d), 0);
    // R9 abort mid-frame
    wr(12'h23C, 32'h0200_0000 | (32'd2 << 22)); wr(12'h248, 32'd1);
    repeat (30) @(posedge clk);
    wr(12'h248, 32'd0); #1;
    rd(12'h24C, d);
    check(d == 0 && mdc == '1 && mdio_oe == '0, "R9 abort", 128'({d[0], mdc, mdio_oe}), 128'({1'b0, {NSEG{1'b1}}, {NSEG{1'b0}}}));
    repeat (40) @(posedge clk);
    #1; rd(12'h24C, d);
    check(d == 0 && mdc == '1, "R9 stays idle", 128'({d[0], mdc}), 128'({1'b0, {NSEG{1'b1}}}));
    // random
    for (int i = 0; i < 10; i++) begin
      bit isint, c45, r;
      isint = 1'($urandom); c45 = 1'($urandom); r = 1'($urandom);
      do_op(isint, int'($urandom % SPS), c45, r, 5'($urandom), 5'($urandom), 16'($urandom),
            16'($urandom), 16'($urandom), isint ? 6 : 5, 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule